// File: doc/BRIEF.md
# Packed Byte SIMD Add Unit

This execution unit adds two 64-bit operands as eight separate 8-bit lanes. No carry crosses a lane boundary, and a lane whose sum overflows keeps only its low eight bits. It produces no status flags. Each operation arrives on a valid/ready input carrying the two opcode bytes, the destination and source operands, and three control-state bits: emulation enabled, task switched, and floating-point exception pending.

Before a result is committed, the unit checks that the opcode pair selects the packed-byte add, and then checks the control state in a fixed priority order. When a fault applies, the unit returns a 3-bit fault code and no result. The output is registered, so there is one cycle from acceptance to output valid. A new operation can be accepted every cycle while the consumer is ready.

Top module: `pbyte_add_unit`

## Requirements
- R1: For every lane k from 0 to 7, result bits 8k+7..8k equal (dst lane k + src lane k) mod 256, and no lane's sum depends on any other lane.
- R2: An overflowing lane wraps and does not saturate. For example 0x80+0x80 gives 0x00, 0xFF+0xFF gives 0xFE and 0x7F+0x01 gives 0x80.
- R3: The add is selected only when opcode byte 0 is 0x0F and opcode byte 1 is 0xFC. Any other pair gives fault code 4 (unrecognised opcode).
- R4: With a recognised opcode and the emulation bit set, the fault code is 1 (invalid opcode).
- R5: With a recognised opcode, the emulation bit clear and the task-switched bit set, the fault code is 2 (device not available).
- R6: With a recognised opcode, emulation and task-switched both clear and an FP exception pending, the fault code is 3 (floating-point error).
- R7: Only one fault is reported, chosen by the priority order 4, then 1, then 2, then 3. Code 0 means no fault.
- R8: A faulted output has out_commit low and out_result zero. out_commit is high exactly when out_valid is high and out_fault is 0.
- R9: out_valid rises in the cycle after an accepting edge. in_ready is high whenever the output slot is empty or out_ready is high, so operations can be accepted back to back.
- R10: While out_valid is high and out_ready is low, out_valid, out_result and out_fault hold their values.
- R11: After a synchronous active-low reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation accepted on this edge if in_valid |
| in_op0 | input | 8 | First opcode byte |
| in_op1 | input | 8 | Second opcode byte |
| in_dst | input | 64 | Destination operand |
| in_src | input | 64 | Source operand |
| in_emu | input | 1 | Emulation control bit |
| in_ts | input | 1 | Task-switched control bit |
| in_fpe | input | 1 | Floating-point exception pending |
| out_valid | output | 1 | Output slot holds a completed operation |
| out_ready | input | 1 | Consumer takes the output on this edge |
| out_result | output | 64 | Lane-wise sum, zero when faulted |
| out_fault | output | 3 | 0 none, 1 invalid opcode, 2 device not available, 3 FP error, 4 unrecognised opcode |
| out_commit | output | 1 | Result write strobe |

## Verification
The properties assume that the producer keeps in_valid and its payload steady until acceptance. They also assume that the consumer may drop out_ready in any cycle, and that the inputs carry known values whenever in_valid is high. The stimulus changes inputs only shortly after a falling edge. It holds each operation until in_ready is seen high, and it drives out_ready from a random pattern only in the backpressure phase. Directed vectors cover carry isolation, wrap values and every combination of fault priority before the random run mixes them.

// File: rtl/pbadd_pkg.sv
// Shared types for the packed byte add unit.
// Assumes lanes are byte wide and the opcode is a fixed two-byte pair.
package pbadd_pkg;
    localparam int LANE_W = 8;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_NODEV   = 3'd2,
        FLT_FPERR   = 3'd3,
        FLT_UNKNOWN = 3'd4
    } fault_e;

    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] ADD_BYTE = 8'hFC;
endpackage

// File: rtl/pbadd_lanes.sv
// Lane adder array: splits both operands into LANE_W-wide lanes and adds
// each pair on its own, dropping the carry out of every lane.
// Assumes DATA_W is a whole multiple of LANE_W.
module pbadd_lanes #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum
);
    localparam int LANES = DATA_W / LANE_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] lane_sum;
        // one lane: modular add, carry discarded
        assign lane_sum = a[k*LANE_W +: LANE_W] + b[k*LANE_W +: LANE_W];
        assign sum[k*LANE_W +: LANE_W] = lane_sum;
    end
endmodule

// File: rtl/pbadd_gate.sv
// Decode and fault gate: recognises the opcode pair and picks the single
// highest-priority fault (unknown opcode, emulation, task switch, FP pending).
// Assumes the control bits are sampled with the operation they accompany.
module pbadd_gate
    import pbadd_pkg::*;
(
    input  logic [7:0] op0,
    input  logic [7:0] op1,
    input  logic       emu,
    input  logic       ts,
    input  logic       fpe,
    output fault_e     fault
);
    logic op_hit;

    assign op_hit = (op0 == ESC_BYTE) && (op1 == ADD_BYTE);

    // fixed-priority fault selection
    always_comb begin
        if (!op_hit)  fault = FLT_UNKNOWN;
        else if (emu) fault = FLT_INVALID;
        else if (ts)  fault = FLT_NODEV;
        else if (fpe) fault = FLT_FPERR;
        else          fault = FLT_NONE;
    end
endmodule

// File: rtl/pbadd_outreg.sv
// Output stage: a single registered slot holding either a result or a fault.
// It takes a new entry whenever the slot is empty or being drained.
// Assumes the producer holds its payload until in_ready is seen high.
module pbadd_outreg
    import pbadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_valid,
    output logic              take_ready,
    input  logic [DATA_W-1:0] take_result,
    input  fault_e            take_fault,
    output logic              slot_valid,
    input  logic              slot_ready,
    output logic [DATA_W-1:0] slot_result,
    output fault_e            slot_fault
);
    assign take_ready = !slot_valid || slot_ready;

    // load, drain or hold the output slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_valid  <= 1'b0;
            slot_result <= '0;
            slot_fault  <= FLT_NONE;
        end else if (take_ready) begin
            slot_valid <= take_valid;
            if (take_valid) begin
                slot_result <= (take_fault == FLT_NONE) ? take_result : '0;
                slot_fault  <= take_fault;
            end
        end
    end
endmodule

// File: rtl/pbyte_add_unit.sv
// Packed byte add unit top: lane adders and the fault gate feed a one-deep
// registered output slot. The commit strobe marks a fault-free output.
// Assumes valid/ready on both sides, with the payload held until accepted.
module pbyte_add_unit
    import pbadd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_op0,
    input  logic [7:0]        in_op1,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [DATA_W-1:0] in_src,
    input  logic              in_emu,
    input  logic              in_ts,
    input  logic              in_fpe,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_result,
    output logic [2:0]        out_fault,
    output logic              out_commit
);
    logic [DATA_W-1:0] sum;
    fault_e            fault;
    fault_e            slot_fault;

    pbadd_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
        .a   (in_dst),
        .b   (in_src),
        .sum (sum)
    );

    pbadd_gate u_gate (
        .op0   (in_op0),
        .op1   (in_op1),
        .emu   (in_emu),
        .ts    (in_ts),
        .fpe   (in_fpe),
        .fault (fault)
    );

    pbadd_outreg #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_valid  (in_valid),
        .take_ready  (in_ready),
        .take_result (sum),
        .take_fault  (fault),
        .slot_valid  (out_valid),
        .slot_ready  (out_ready),
        .slot_result (out_result),
        .slot_fault  (slot_fault)
    );

    assign out_fault  = slot_fault;
    assign out_commit = out_valid && (slot_fault == FLT_NONE);
endmodule

// File: rtl/pbadd_chk.sv
// Checker for the packed byte add unit, bound onto every instance of the top.
module pbadd_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_op0,
    input logic [7:0]        in_op1,
    input logic [DATA_W-1:0] in_dst,
    input logic [DATA_W-1:0] in_src,
    input logic              in_emu,
    input logic              in_ts,
    input logic              in_fpe,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_result,
    input logic [2:0]        out_fault,
    input logic              out_commit
);
    function automatic logic [DATA_W-1:0] ref_sum(input logic [DATA_W-1:0] x,
                                                  input logic [DATA_W-1:0] y);
        logic [DATA_W-1:0] r;
        logic [8:0] wide;
        r = '0;
        for (int k = 0; k < DATA_W / 8; k++) begin
            wide = {1'b0, x[k*8 +: 8]} + {1'b0, y[k*8 +: 8]};
            r[k*8 +: 8] = wide[7:0];
        end
        return r;
    endfunction

    logic accept, op_ok;
    assign accept = in_valid && in_ready;
    assign op_ok  = (in_op0 == 8'h0F) && (in_op1 == 8'hFC);

    // R1
    lane_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_ok && !in_emu && !in_ts && !in_fpe |=>
            out_valid && out_commit && out_result == ref_sum($past(in_dst), $past(in_src)));

    // R3
    bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !op_ok |=> out_fault == 3'd4);

    // R4
    emu_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_ok && in_emu |=> out_fault == 3'd1);

    // R5
    ts_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_ok && !in_emu && in_ts |=> out_fault == 3'd2);

    // R6
    fpe_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_ok && !in_emu && !in_ts && in_fpe |=> out_fault == 3'd3);

    // R7
    fault_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_fault <= 3'd4);

    // R8
    fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fault != 3'd0 |-> !out_commit && out_result == '0);

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> out_valid);

    // R9
    ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_fault));
endmodule

bind pbyte_add_unit pbadd_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pbyte_add_unit.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops them.
module sim_pbyte_add_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_op0 = 8'h0F, in_op1 = 8'hFC;
    logic [63:0] in_dst = '0, in_src = '0;
    logic        in_emu = 1'b0, in_ts = 1'b0, in_fpe = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [63:0] out_result;
    logic [2:0]  out_fault;
    logic        out_commit;

    always #10 clk = ~clk;

    pbyte_add_unit u0 (.*);

    typedef struct {
        logic [63:0] res;
        logic [2:0]  flt;
        string       tag;
        int          acc;
        bit          timed;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    bit   bp_on  = 1'b0;
    bit   done   = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] model_sum(input logic [63:0] d, input logic [63:0] s);
        logic [63:0] r;
        for (int k = 0; k < 8; k++) r[k*8 +: 8] = 8'(d[k*8 +: 8] + s[k*8 +: 8]);
        return r;
    endfunction

    function automatic logic [2:0] model_fault(input logic [7:0] a, input logic [7:0] b,
                                               input bit e, input bit t, input bit f);
        if (a != 8'h0F || b != 8'hFC) return 3'd4;
        if (e) return 3'd1;
        if (t) return 3'd2;
        if (f) return 3'd3;
        return 3'd0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] a, input logic [7:0] b,
                         input logic [63:0] d, input logic [63:0] s,
                         input bit e, input bit t, input bit f,
                         input string tag, input bit timed);
        exp_t x;
        @(negedge clk);
        #1;
        in_op0 = a; in_op1 = b; in_dst = d; in_src = s;
        in_emu = e; in_ts = t; in_fpe = f; in_valid = 1'b1;
        #7;
        while (!in_ready) begin
            @(negedge clk);
            #8;
        end
        x.flt = model_fault(a, b, e, t, f);
        x.res = (x.flt == 3'd0) ? model_sum(d, s) : 64'd0;
        x.tag = tag;
        x.acc = cyc;
        x.timed = timed;
        q.push_back(x);
    endtask

    task automatic idle();
        @(negedge clk);
        #1 in_valid = 1'b0;
    endtask

    // consumer readiness: always ready unless backpressure is on
    initial forever begin
        @(negedge clk);
        #1 out_ready = bp_on ? $urandom_range(0, 2) != 0 : 1'b1;
    end

    // monitor: compares outputs just before the rising edge that takes them
    initial begin
        logic [63:0] held_r;
        logic [2:0]  held_f;
        bit          armed;
        exp_t        e;
        armed = 1'b0;
        held_r = '0;
        held_f = '0;
        forever begin
            @(negedge clk);
            #8;
            if (rst_n) begin
                if (armed) begin
                    // R10 stalled output holds
                    check("R10 hold valid", {63'd0, out_valid}, 64'd1);
                    check("R10 hold result", out_result, held_r);
                    check("R10 hold fault", {61'd0, out_fault}, {61'd0, held_f});
                end
                armed  = out_valid && !out_ready;
                held_r = out_result;
                held_f = out_fault;
                if (out_valid && out_ready) begin
                    if (q.size() == 0) begin
                        check("R9 unexpected output", 64'd1, 64'd0);
                    end else begin
                        e = q.pop_front();
                        check({e.tag, " result"}, out_result, e.res);
                        check({e.tag, " fault"}, {61'd0, out_fault}, {61'd0, e.flt});
                        // R8 commit strobe
                        check("R8 commit", {63'd0, out_commit}, {63'd0, e.flt == 3'd0});
                        // R9 one-cycle latency
                        if (e.timed) check("R9 latency", 64'(cyc), 64'(e.acc + 1));
                    end
                end
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        #7;
        // R11 reset state
        check("R11 out_valid", {63'd0, out_valid}, 64'd0);
        check("R11 in_ready", {63'd0, in_ready}, 64'd1);

        // R1 basic and carry isolation, back to back
        drive(8'h0F, 8'hFC, 64'h0102030405060708, 64'h1010101010101010, 0, 0, 0, "R1 basic", 1);
        drive(8'h0F, 8'hFC, 64'h00FF00FF00FF00FF, 64'h0001000100010001, 0, 0, 0, "R1 carry cut", 1);
        drive(8'h0F, 8'hFC, 64'hFF00FF00FF00FF00, 64'h0100010001000100, 0, 0, 0, "R1 carry cut hi", 1);
        // R2 wrap, no saturation
        drive(8'h0F, 8'hFC, 64'h8080FFFF7F7F0102, 64'h8080FFFF01010203, 0, 0, 0, "R2 wrap", 1);
        // R4 R5 R6 single faults
        drive(8'h0F, 8'hFC, 64'h1111111111111111, 64'h2222222222222222, 1, 0, 0, "R4 emu", 1);
        drive(8'h0F, 8'hFC, 64'h1111111111111111, 64'h2222222222222222, 0, 1, 0, "R5 ts", 1);
        drive(8'h0F, 8'hFC, 64'h1111111111111111, 64'h2222222222222222, 0, 0, 1, "R6 fpe", 1);
        // R7 priority combinations
        drive(8'h0F, 8'hFC, 64'h1, 64'h2, 1, 1, 1, "R7 emu first", 1);
        drive(8'h0F, 8'hFC, 64'h1, 64'h2, 0, 1, 1, "R7 ts over fpe", 1);
        drive(8'h0E, 8'hFC, 64'h1, 64'h2, 1, 1, 1, "R7 unknown first", 1);
        // R3 decode misses
        drive(8'h0F, 8'hFD, 64'h1, 64'h2, 0, 0, 0, "R3 op1 miss", 1);
        drive(8'hFC, 8'h0F, 64'h1, 64'h2, 0, 0, 0, "R3 swapped", 1);
        idle();

        // random mix under backpressure (R1 R8 R10)
        bp_on = 1'b1;
        for (int i = 0; i < 60; i++) begin
            logic [2:0] sel;
            sel = 3'($urandom_range(0, 7));
            drive((sel == 3'd7) ? 8'h0E : 8'h0F, 8'hFC, {$urandom, $urandom}, {$urandom, $urandom},
                  sel == 3'd4, sel == 3'd5, sel == 3'd6, "R1 random", 0);
            if (sel == 3'd2) idle();
        end
        idle();
        bp_on = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule